// File: doc/BRIEF.md
# Clock Mode Switch Sequencer

This block sequences the clock and power modes of a small 8-bit controller. It holds a register that software can read and write. From that register and a small mode register it drives the active clock mode (low, middle or high speed), the enable of the main oscillator, and a stop indication. While the core runs from the slow sub-clock, software can request a hardware-timed move to middle speed. The block turns on the main oscillator, counts a selectable number of machine-cycle ticks so the oscillator can settle, and then changes the mode by itself.

A stop request halts the clocks. An external interrupt releases the stop. When the interrupt releases the stop, the block either loads fixed settling values into a timer and its prescaler, or leaves the values that software placed there. It then returns to the clock mode that was active before the stop. The register port is a single-cycle write strobe with an address and a combinational read path. The timer and prescaler are held here only as values. They are not counted.

Top module: `clkmode_seq`

## Requirements
- R1: After reset the clock mode is middle speed (code 1), the main oscillator is enabled, the block is not stopped, the done pulse is low, and the control register reads 0x00.
- R2: The register map is: address 0 is control, 1 is mode, 2 is timer, 3 is prescaler. Control bits 7..4 always read 0. Control bits 2..0 read back as last written. Timer and prescaler read back as written.
- R3: Control bit 3 is the start command. A control write with bit 3 set starts a switch only when bit 1 of the same write is 1, the mode is low speed and the block is idle. Under any other condition the start has no effect: the mode and the oscillator enable are unchanged, and bit 3 reads 0.
- R4: In the cycle after an accepted start, the main oscillator enable is 1, the mode is still low speed, and control bit 3 reads 1.
- R5: After an accepted start, the block counts machine-cycle ticks; a tick in the start cycle itself is not counted. The mode becomes middle speed at the edge of the 5th counted tick when control bit 2 was 0 at start, or of the 7th when it was 1.
- R6: On completion a one-cycle done pulse is raised together with the mode change, and control bit 3 is cleared by hardware.
- R7: While a switch is in progress, stop requests, mode register writes and further start commands are ignored.
- R8: A stop request while running and idle sets the stopped output, drives the oscillator enable to 0, and holds the mode output.
- R9: An interrupt release during stop with control bit 0 equal to 0 loads 0x01 into the timer and 0xFF into the prescaler. With bit 0 equal to 1, both keep their earlier values. In both cases the block resumes the prior mode. An interrupt release while not stopped has no effect.
- R10: Mode writes take codes 0 (low), 1 (middle) and 2 (high); code 3 is ignored. While running, the oscillator enable is 1 exactly when the mode is not low speed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the addressed register |
| mc_tick | input | 1 | One-cycle machine-cycle tick |
| stop_req | input | 1 | Request to enter stop |
| irq_wake | input | 1 | External interrupt release from stop |
| clk_mode | output | 2 | Active clock mode: 0 low, 1 middle, 2 high |
| main_osc_en | output | 1 | Main oscillator enable |
| stopped | output | 1 | Block is in stop state |
| switch_done | output | 1 | One-cycle pulse when an automatic switch completes |
| tmr_val | output | 8 | Current timer value |
| pre_val | output | 8 | Current prescaler value |

## Verification
The hardest cases are the boundaries of the settling window. A tick that arrives in the same cycle as the start write must not be counted. Disturbances that arrive in the middle of the wait must not change anything. To reach both, the bench sweeps the wait select against tick spacings of one to three cycles, with and without a tick beside the start write. In the middle of each wait it injects a stop request, a mode write and a repeated start, and it checks the cycle of the mode change against the tick count it computes.

// File: rtl/clkmode_pkg.sv
package clkmode_pkg;
  typedef logic [1:0] cmode_t;
  localparam cmode_t MODE_LOW  = 2'd0;
  localparam cmode_t MODE_MID  = 2'd1;
  localparam cmode_t MODE_HIGH = 2'd2;

  localparam logic [1:0] A_CTL  = 2'd0;
  localparam logic [1:0] A_MODE = 2'd1;
  localparam logic [1:0] A_TMR  = 2'd2;
  localparam logic [1:0] A_PRE  = 2'd3;

  typedef enum logic [1:0] {ST_RUN = 2'd0, ST_SWITCH = 2'd1, ST_STOP = 2'd2} seq_state_e;

  // a mode code is accepted unless it is the reserved value
  function automatic logic mode_code_ok(input cmode_t code);
    return code != 2'd3;
  endfunction

  // settling target in ticks for the chosen wait select
  function automatic int unsigned settle_ticks(input logic long_sel, input int unsigned short_n,
                                               input int unsigned long_n);
    return long_sel ? long_n : short_n;
  endfunction
endpackage

// File: rtl/clkmode_fsm.sv
module clkmode_fsm
  import clkmode_pkg::*;
#(
  parameter int unsigned SHORT_WAIT = 5,
  parameter int unsigned LONG_WAIT  = 7,
  localparam int unsigned MAXW  = (SHORT_WAIT > LONG_WAIT) ? SHORT_WAIT : LONG_WAIT,
  localparam int unsigned CNT_W = $clog2(MAXW + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mc_tick,
  input  logic       stop_req,
  input  logic       irq_wake,
  input  logic       start_req,
  input  logic       wait_long,
  input  logic       mode_is_low,
  output seq_state_e state,
  output logic       start_evt,
  output logic       finish_evt,
  output logic       stop_evt,
  output logic       wake_evt
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] target_q;
  logic [CNT_W-1:0] target_d;

  assign target_d   = CNT_W'(settle_ticks(wait_long, SHORT_WAIT, LONG_WAIT));
  assign start_evt  = start_req && mode_is_low && (state == ST_RUN);
  assign stop_evt   = stop_req && (state == ST_RUN) && !start_evt;
  assign wake_evt   = irq_wake && (state == ST_STOP);
  assign finish_evt = (state == ST_SWITCH) && mc_tick && (cnt_q == target_q - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_RUN;
      cnt_q    <= '0;
      target_q <= '0;
    end else begin
      unique case (state)
        ST_RUN: begin
          if (start_evt) begin
            state    <= ST_SWITCH;
            cnt_q    <= '0;
            target_q <= target_d;
          end else if (stop_evt) begin
            state <= ST_STOP;
          end
        end
        ST_SWITCH: begin
          if (finish_evt) begin
            state <= ST_RUN;
            cnt_q <= '0;
          end else if (mc_tick) begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_STOP: begin
          if (wake_evt) state <= ST_RUN;
        end
        default: state <= ST_RUN;
      endcase
    end
  end
endmodule

// File: rtl/clkmode_regs.sv
module clkmode_regs
  import clkmode_pkg::*;
#(
  parameter int unsigned DW = 8,
  parameter logic [DW-1:0] TMR_WAKE = 8'h01,
  parameter logic [DW-1:0] PRE_WAKE = 8'hFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  input  logic          start_evt,
  input  logic          finish_evt,
  input  logic          wake_evt,
  input  logic          mode_wr_ok,
  output logic [DW-1:0] reg_rdata,
  output cmode_t        mode_q,
  output logic          keep_on_wake,
  output logic [DW-1:0] tmr_q,
  output logic [DW-1:0] pre_q
);
  logic [2:0] ctl_q;
  logic       busy_q;
  logic       wr_ctl, wr_mode, wr_tmr, wr_pre;

  assign wr_ctl  = reg_wr && (reg_addr == A_CTL);
  assign wr_mode = reg_wr && (reg_addr == A_MODE);
  assign wr_tmr  = reg_wr && (reg_addr == A_TMR);
  assign wr_pre  = reg_wr && (reg_addr == A_PRE);
  assign keep_on_wake = ctl_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      busy_q <= 1'b0;
      mode_q <= MODE_MID;
      tmr_q  <= '0;
      pre_q  <= '0;
    end else begin
      if (wr_ctl) ctl_q <= reg_wdata[2:0];
      if (start_evt) busy_q <= 1'b1;
      else if (finish_evt) busy_q <= 1'b0;
      if (finish_evt) mode_q <= MODE_MID;
      else if (wr_mode && mode_wr_ok && mode_code_ok(reg_wdata[1:0])) mode_q <= reg_wdata[1:0];
      if (wake_evt && !ctl_q[0]) begin
        tmr_q <= TMR_WAKE;
        pre_q <= PRE_WAKE;
      end else begin
        if (wr_tmr) tmr_q <= reg_wdata;
        if (wr_pre) pre_q <= reg_wdata;
      end
    end
  end

  always_comb begin
    unique case (reg_addr)
      A_CTL:   reg_rdata = {{(DW-4){1'b0}}, busy_q, ctl_q};
      A_MODE:  reg_rdata = {{(DW-2){1'b0}}, mode_q};
      A_TMR:   reg_rdata = tmr_q;
      default: reg_rdata = pre_q;
    endcase
  end
endmodule

// File: rtl/clkmode_seq.sv
module clkmode_seq
  import clkmode_pkg::*;
#(
  parameter int unsigned SHORT_WAIT = 5,
  parameter int unsigned LONG_WAIT  = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       mc_tick,
  input  logic       stop_req,
  input  logic       irq_wake,
  output logic [1:0] clk_mode,
  output logic       main_osc_en,
  output logic       stopped,
  output logic       switch_done,
  output logic [7:0] tmr_val,
  output logic [7:0] pre_val
);
  seq_state_e state;
  cmode_t     mode_q;
  logic start_req, start_evt, finish_evt, stop_evt, wake_evt, keep_on_wake, done_q;

  // a start attempt: control write carrying both the start and enable bits
  assign start_req = reg_wr && (reg_addr == A_CTL) && reg_wdata[3] && reg_wdata[1];

  clkmode_fsm #(.SHORT_WAIT(SHORT_WAIT), .LONG_WAIT(LONG_WAIT)) u_fsm (
    .clk(clk), .rst_n(rst_n), .mc_tick(mc_tick), .stop_req(stop_req), .irq_wake(irq_wake),
    .start_req(start_req), .wait_long(reg_wdata[2]), .mode_is_low(mode_q == MODE_LOW),
    .state(state), .start_evt(start_evt), .finish_evt(finish_evt), .stop_evt(stop_evt),
    .wake_evt(wake_evt)
  );

  clkmode_regs #(.DW(8)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .start_evt(start_evt), .finish_evt(finish_evt), .wake_evt(wake_evt),
    .mode_wr_ok(state == ST_RUN), .reg_rdata(reg_rdata), .mode_q(mode_q),
    .keep_on_wake(keep_on_wake), .tmr_q(tmr_val), .pre_q(pre_val)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= finish_evt;
  end

  assign clk_mode    = mode_q;
  assign stopped     = (state == ST_STOP);
  assign main_osc_en = (state == ST_SWITCH) || ((state == ST_RUN) && (mode_q != MODE_LOW));
  assign switch_done = done_q;
endmodule

// File: rtl/clkmode_seq_chk.sv
module clkmode_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] reg_addr,
  input logic [7:0] reg_rdata,
  input logic [1:0] clk_mode,
  input logic       main_osc_en,
  input logic       stopped,
  input logic       switch_done,
  input logic       irq_wake,
  input logic       start_evt,
  input logic       stop_evt
);
  p_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 2'd0) |-> (reg_rdata[7:4] == 4'd0));
  p_start_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |-> (clk_mode == 2'd0));
  p_start_osc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (main_osc_en && clk_mode == 2'd0));
  p_done_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
    switch_done |-> (clk_mode == 2'd1));
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    switch_done |=> !switch_done);
  p_stop_osc_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stopped |-> !main_osc_en);
  p_stop_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stopped && !irq_wake) |=> (stopped && $stable(clk_mode)));
  p_stop_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> stopped);
endmodule

bind clkmode_seq clkmode_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rdata(reg_rdata), .clk_mode(clk_mode),
  .main_osc_en(main_osc_en), .stopped(stopped), .switch_done(switch_done), .irq_wake(irq_wake),
  .start_evt(start_evt), .stop_evt(stop_evt)
);

// File: tb/clkmode_seq_bench.sv
module clkmode_seq_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0, mc_tick = 1'b0, stop_req = 1'b0, irq_wake = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0, reg_rdata, tmr_val, pre_val;
  logic [1:0] clk_mode;
  logic main_osc_en, stopped, switch_done;
  int vecs = 0, errs = 0;

  always #4 clk = ~clk;

  clkmode_seq u_clkmode_seq (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .mc_tick(mc_tick), .stop_req(stop_req), .irq_wake(irq_wake),
    .clk_mode(clk_mode), .main_osc_en(main_osc_en), .stopped(stopped),
    .switch_done(switch_done), .tmr_val(tmr_val), .pre_val(pre_val)
  );

  task automatic chk(input string req, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d, input logic tk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d; mc_tick = tk;
    cyc();
    reg_wr = 1'b0; mc_tick = 1'b0;
  endtask

  task automatic rd(input string req, input logic [1:0] a, input int exp);
    reg_addr = a;
    #1;
    chk(req, reg_rdata, exp);
  endtask

  task automatic pulse_stop();  stop_req = 1'b1; cyc(); stop_req = 1'b0; endtask
  task automatic pulse_wake();  irq_wake = 1'b1; cyc(); irq_wake = 1'b0; endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    int n;
    cyc(); cyc();
    rst_n = 1'b1;
    cyc();
    // R1 reset state
    chk("R1 mode", clk_mode, 1);
    chk("R1 osc", main_osc_en, 1);
    chk("R1 stopped", stopped, 0);
    chk("R1 done", switch_done, 0);
    rd("R1 ctl", 2'd0, 0);
    // R2 register map and unused bits
    wr(2'd0, 8'hF5, 1'b0);
    rd("R2 ctl upper", 2'd0, 8'h05);
    wr(2'd2, 8'h3C, 1'b0);
    rd("R2 tmr", 2'd2, 8'h3C);
    wr(2'd3, 8'hA5, 1'b0);
    rd("R2 pre", 2'd3, 8'hA5);
    // R3 start refused outside low speed
    wr(2'd0, 8'hFF, 1'b0);
    rd("R3 not low", 2'd0, 8'h07);
    chk("R3 mode", clk_mode, 1);
    // R10 mode codes
    wr(2'd1, 8'h00, 1'b0);
    chk("R10 low", clk_mode, 0);
    chk("R10 osc low", main_osc_en, 0);
    wr(2'd1, 8'h02, 1'b0);
    chk("R10 high", clk_mode, 2);
    chk("R10 osc high", main_osc_en, 1);
    wr(2'd1, 8'h03, 1'b0);
    chk("R10 code3", clk_mode, 2);
    wr(2'd1, 8'h00, 1'b0);
    // R3 start refused without enable bit
    wr(2'd0, 8'h08, 1'b0);
    chk("R3 no enable osc", main_osc_en, 0);
    rd("R3 no enable bit3", 2'd0, 0);
    repeat (8) begin mc_tick = 1'b1; cyc(); mc_tick = 1'b0; end
    chk("R3 no enable mode", clk_mode, 0);

    // R4 R5 R6 R7 sweep
    for (int ws = 0; ws < 2; ws++)
      for (int k = 1; k <= 3; k++)
        for (int ts = 0; ts < 2; ts++) begin
          n = (ws != 0) ? 7 : 5;
          wr(2'd1, 8'h00, 1'b0);
          wr(2'd0, 8'(8'h0A | (ws << 2)), ts[0]);
          chk("R4 osc", main_osc_en, 1);
          chk("R4 mode", clk_mode, 0);
          rd("R4 bit3", 2'd0, 8'h0A | (ws << 2));
          for (int t = 1; t <= n; t++) begin
            if (t == 2) begin
              pulse_stop();
              wr(2'd1, 8'h02, 1'b0);
              wr(2'd0, 8'(8'h0A | (ws << 2)), 1'b0);
              chk("R7 not stopped", stopped, 0);
              chk("R7 mode", clk_mode, 0);
              chk("R7 osc", main_osc_en, 1);
            end
            repeat (k - 1) cyc();
            mc_tick = 1'b1; cyc(); mc_tick = 1'b0;
            if (t < n) begin
              chk("R5 early", clk_mode, 0);
              chk("R6 no done", switch_done, 0);
            end else begin
              chk("R5 switch", clk_mode, 1);
              chk("R6 done", switch_done, 1);
              rd("R6 bit3 clear", 2'd0, ws << 2 | 2);
            end
          end
          cyc();
          chk("R6 pulse", switch_done, 0);
        end

    // R8 R9 stop with fixed preload
    wr(2'd0, 8'h00, 1'b0);
    wr(2'd1, 8'h02, 1'b0);
    wr(2'd2, 8'h3C, 1'b0);
    wr(2'd3, 8'hA5, 1'b0);
    irq_wake = 1'b1; cyc(); irq_wake = 1'b0;
    chk("R9 wake while running", tmr_val, 8'h3C);
    pulse_stop();
    chk("R8 stopped", stopped, 1);
    chk("R8 osc", main_osc_en, 0);
    repeat (3) cyc();
    chk("R8 hold", clk_mode, 2);
    pulse_wake();
    chk("R9 run", stopped, 0);
    chk("R9 mode", clk_mode, 2);
    chk("R9 osc", main_osc_en, 1);
    chk("R9 tmr", tmr_val, 8'h01);
    chk("R9 pre", pre_val, 8'hFF);
    // R9 keep values
    wr(2'd0, 8'h01, 1'b0);
    wr(2'd2, 8'h77, 1'b0);
    wr(2'd3, 8'h12, 1'b0);
    wr(2'd1, 8'h00, 1'b0);
    pulse_stop();
    chk("R8 stopped low", stopped, 1);
    pulse_wake();
    chk("R9 keep tmr", tmr_val, 8'h77);
    chk("R9 keep pre", pre_val, 8'h12);
    chk("R9 keep mode", clk_mode, 0);
    chk("R10 osc after wake", main_osc_en, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule